// File: doc/BRIEF.md
# Three-Phase Sinusoidal PWM Modulator

This block turns a phase-increment word and a modulation amplitude into three gate signals whose duty cycles follow a sine wave, with the three phases 120 degrees apart. A single sine evaluator serves all three phases. A small sequencer feeds it the phase of A, then B, then C at the start of each carrier period. Each result is scaled into an 8-bit duty value and held in a staging register for its phase.

Each phase has its own up-counting carrier comparator. All three comparators take their staged duty together on the last count of a period, so a new duty never appears partway through a period. The phase accumulator advances once per carrier period. The output frequency is therefore `freq_word / 65536` of the carrier rate. The carrier rate is the enabled clock rate divided by 256; a clock near 766 MHz gives a carrier near 2.99 MHz.

Top module: `spwm3_mod`

## Requirements
- R1: After reset, every output is low and stays low for the whole first carrier period of 256 enabled cycles, because the applied duty resets to 0.
- R2: Each phase has an 8-bit carrier count that advances by one on every enabled clock and wraps 255 to 0. A phase output is high exactly when its count is below its applied duty. The three counts always agree.
- R3: The sine sample for a 16-bit phase is computed as follows. Take i = phase[15:6] and x = i[8:0], then m = min(127, floor(x*(512-x)/512)). The sample is -m when i[9] is 1 and +m otherwise.
- R4: The duty is 128 + floor(s*a/256), where s is the signed sine sample and a is `mod_amp` taken as an unsigned value from 0 to 255.
- R5: Phase A uses the accumulator value. Phase B uses accumulator + 21845 and phase C uses accumulator + 43690, both modulo 65536.
- R6: The duties computed in the first enabled cycles of carrier period n are applied together from the first cycle of period n+1. An applied duty changes only on the enabled clock that leaves count 255.
- R7: The phase accumulator starts at 0 and adds `freq_word` once per carrier period, modulo 65536, after that period's three samples have been taken. `freq_word` and `mod_amp` are sampled within the first five enabled cycles of a period.
- R8: While `en` is low, the counts, the sequencer, the accumulator and all registers hold, so every output keeps its value.
- R9: With `mod_amp` equal to 0, all three phases get duty 128, which is high for exactly half of each period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Clock enable for the whole block |
| freq_word | input | 16 | Phase increment added once per carrier period |
| mod_amp | input | 8 | Modulation amplitude, unsigned |
| out_a | output | 1 | Gate signal, phase A |
| out_b | output | 1 | Gate signal, phase B |
| out_c | output | 1 | Gate signal, phase C |

## Verification
The hardest case to reach from the ports is an enable gap that lands inside the five-cycle sequencing window or on the count-255 load cycle. If the design mishandles it, a stale or half-built set of duties is applied to the next period. The stimulus draws a fresh random frequency and amplitude every period. In a band of periods it drops `en` randomly, and much more often near the period boundary, so that gaps hit the sequencer states and the load cycle. Directed periods with zero amplitude, full amplitude, a zero increment and a near-full-scale increment exercise the duty extremes and the accumulator wrap.

// File: rtl/spwm3_pkg.sv
package spwm3_pkg;

  // Sequencer states: wait for period start, then one state per phase request,
  // then a final state in which the last sample is staged and the phase advances.
  typedef enum logic [2:0] {
    SQ_IDLE = 3'd0,
    SQ_REQ_A = 3'd1,
    SQ_REQ_B = 3'd2,
    SQ_REQ_C = 3'd3,
    SQ_FIN   = 3'd4
  } seq_st_e;

  localparam int NUM_PH = 3;

endpackage

// File: rtl/spwm3_sine.sv
// Shared sine evaluator: parabolic half-wave approximation, one registered sample
// per enabled cycle.
module spwm3_sine #(
  parameter int PW = 16,  // phase word width
  parameter int SW = 8    // sample / PWM resolution
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ce,
  input  logic [PW-1:0]        phase_i,
  output logic signed [SW-1:0] smp_o
);

  localparam int HB   = SW + 1;           // index bits within a half cycle
  localparam int IB   = HB + 1;           // index bits including half select
  localparam int PRW  = 2 * HB + 1;       // product width
  localparam int MAXV = (1 << (SW - 1)) - 1;

  logic [IB-1:0]  idx;
  logic [HB-1:0]  x_pos;
  logic [HB:0]    x_rem;
  logic [PRW-1:0] prod;
  logic [HB:0]    mag_full;
  logic [SW-1:0]  mag;
  logic [SW-1:0]  smp_d;
  logic [SW-1:0]  smp_q;
  logic           unused_sine_bits;

  assign idx   = phase_i[PW-1 -: IB];
  assign x_pos = idx[HB-1:0];
  assign x_rem = (HB+1)'(1 << HB) - {1'b0, x_pos};
  assign prod  = PRW'(x_pos) * PRW'(x_rem);
  assign mag_full = prod[PRW-1 -: (HB+1)];
  assign unused_sine_bits = ^{prod[HB-1:0], phase_i[PW-IB-1:0]};

  always_comb begin
    if (mag_full > (HB+1)'(MAXV)) begin
      mag = SW'(MAXV);
    end else begin
      mag = mag_full[SW-1:0];
    end
    if (idx[IB-1]) begin
      smp_d = SW'(-mag);
    end else begin
      smp_d = mag;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q <= '0;
    end else if (ce) begin
      smp_q <= smp_d;
    end
  end

  assign smp_o = $signed(smp_q);

  // R8: the sample register holds while the enable is low
  assert_sine_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> $stable(smp_q));

endmodule

// File: rtl/spwm3_seq.sv
// Sequencer: owns the phase accumulator and walks A, B, C through the shared
// sine evaluator once per carrier period.
module spwm3_seq
  import spwm3_pkg::*;
#(
  parameter int PW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              wrap_i,
  input  logic [PW-1:0]     freq_i,
  output logic [PW-1:0]     phase_o,
  output logic [NUM_PH-1:0] stage_en_o
);

  localparam logic [PW-1:0] OFS_B = PW'((64'd1 << PW) / 3);
  localparam logic [PW-1:0] OFS_C = PW'(2 * ((64'd1 << PW) / 3));

  seq_st_e       st_q, st_d;
  logic          pend_q, pend_d;
  logic [PW-1:0] acc_q, acc_d;

  // next-state process
  always_comb begin
    st_d   = st_q;
    pend_d = pend_q;
    acc_d  = acc_q;
    if (en) begin
      unique case (st_q)
        SQ_IDLE: begin
          if (pend_q) begin
            st_d   = SQ_REQ_A;
            pend_d = 1'b0;
          end
        end
        SQ_REQ_A: st_d = SQ_REQ_B;
        SQ_REQ_B: st_d = SQ_REQ_C;
        SQ_REQ_C: st_d = SQ_FIN;
        SQ_FIN: begin
          st_d  = SQ_IDLE;
          acc_d = acc_q + freq_i;
        end
        default: st_d = SQ_IDLE;
      endcase
      if (wrap_i) begin
        pend_d = 1'b1;
      end
    end
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      pend_q <= 1'b1;
      acc_q  <= '0;
    end else begin
      st_q   <= st_d;
      pend_q <= pend_d;
      acc_q  <= acc_d;
    end
  end

  always_comb begin
    unique case (st_q)
      SQ_REQ_B: phase_o = acc_q + OFS_B;
      SQ_REQ_C: phase_o = acc_q + OFS_C;
      default:  phase_o = acc_q;
    endcase
  end

  // The sample requested in one state is valid in the next one.
  assign stage_en_o[0] = en && (st_q == SQ_REQ_B);
  assign stage_en_o[1] = en && (st_q == SQ_REQ_C);
  assign stage_en_o[2] = en && (st_q == SQ_FIN);

  // R6: at most one staging register is written per cycle
  assert_one_stage_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(stage_en_o));

  // R7: the accumulator moves only when leaving the final state
  assert_acc_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_q != $past(acc_q)) |-> $past(en && st_q == SQ_FIN));

  // R8: sequencer state holds while disabled
  assert_seq_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(st_q) && $stable(acc_q)));

endmodule

// File: rtl/spwm3_stage.sv
// Per-phase staging register: scales a signed sample into an unsigned duty.
module spwm3_stage #(
  parameter int SW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ce,
  input  logic signed [SW-1:0] smp_i,
  input  logic [SW-1:0]        amp_i,
  output logic [SW-1:0]        duty_o
);

  localparam int PRW = 2 * SW + 1;
  localparam logic [SW-1:0] MID = SW'(1 << (SW - 1));

  logic signed [SW:0]    amp_s;
  logic signed [PRW-1:0] prod;
  logic [SW-1:0]         duty_d;
  logic [SW-1:0]         duty_q;
  logic                  unused_stage_bits;

  assign amp_s  = $signed({1'b0, amp_i});
  assign prod   = PRW'(smp_i) * PRW'(amp_s);
  // bits [2SW-1:SW] are the floor of prod / 2^SW, truncated to SW bits
  assign duty_d = MID + prod[2*SW-1:SW];
  assign unused_stage_bits = ^{prod[PRW-1], prod[SW-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty_q <= '0;
    end else if (ce) begin
      duty_q <= duty_d;
    end
  end

  assign duty_o = duty_q;

  // R4: a zero amplitude always stages the mid-scale duty
  assert_zero_amp_mid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && amp_i == '0) |=> (duty_q == MID));

endmodule

// File: rtl/spwm3_pwm.sv
// Single-phase carrier comparator with a load-gated duty register.
module spwm3_pwm #(
  parameter int SW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          ld_i,
  input  logic [SW-1:0] duty_i,
  output logic          pwm_o,
  output logic          wrap_o
);

  logic [SW-1:0] cnt_q, cnt_d;
  logic [SW-1:0] duty_q, duty_d;

  always_comb begin
    cnt_d  = cnt_q;
    duty_d = duty_q;
    if (en) begin
      cnt_d = cnt_q + SW'(1);
      if (ld_i) begin
        duty_d = duty_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      duty_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      duty_q <= duty_d;
    end
  end

  assign wrap_o = (cnt_q == '1);
  assign pwm_o  = (cnt_q < duty_q);

  // R2: the carrier advances by one on every enabled cycle
  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> (cnt_q == $past(cnt_q) + SW'(1)));

  // R6: loads are requested only on the last count of a period
  assert_load_at_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && ld_i) |-> wrap_o);

  // R6: the applied duty changes only through a load
  assert_duty_by_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_q != $past(duty_q)) |-> $past(en && ld_i));

  // R8: output frozen while disabled
  assert_out_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(pwm_o));

endmodule

// File: rtl/spwm3_mod.sv
module spwm3_mod
  import spwm3_pkg::*;
#(
  parameter int PW = 16,
  parameter int SW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [PW-1:0] freq_word,
  input  logic [SW-1:0] mod_amp,
  output logic          out_a,
  output logic          out_b,
  output logic          out_c
);

  logic [PW-1:0]        phase;
  logic signed [SW-1:0] smp;
  logic [NUM_PH-1:0]    stage_en;
  logic [NUM_PH-1:0]    wrap;
  logic [NUM_PH-1:0]    pwm;
  logic [SW-1:0]        duty_stg [NUM_PH];

  spwm3_seq #(.PW(PW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .wrap_i     (wrap[0]),
    .freq_i     (freq_word),
    .phase_o    (phase),
    .stage_en_o (stage_en)
  );

  spwm3_sine #(.PW(PW), .SW(SW)) u_sine (
    .clk     (clk),
    .rst_n   (rst_n),
    .ce      (en),
    .phase_i (phase),
    .smp_o   (smp)
  );

  for (genvar k = 0; k < NUM_PH; k++) begin : g_phase
    spwm3_stage #(.SW(SW)) u_stage (
      .clk    (clk),
      .rst_n  (rst_n),
      .ce     (stage_en[k]),
      .smp_i  (smp),
      .amp_i  (mod_amp),
      .duty_o (duty_stg[k])
    );

    spwm3_pwm #(.SW(SW)) u_pwm (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (en),
      .ld_i   (wrap[0]),
      .duty_i (duty_stg[k]),
      .pwm_o  (pwm[k]),
      .wrap_o (wrap[k])
    );
  end

  assign out_a = pwm[0];
  assign out_b = pwm[1];
  assign out_c = pwm[2];

  // R2: the three carriers stay in lock
  assert_carrier_lock_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap == '0) || (wrap == '1));

endmodule

// File: tb/spwm3_mod_bench.sv
module spwm3_mod_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        en;
  logic [15:0] freq_w;
  logic [7:0]  amp;
  logic        out_a, out_b, out_c;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  spwm3_mod u_spwm3_mod (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .freq_word (freq_w),
    .mod_amp   (amp),
    .out_a     (out_a),
    .out_b     (out_b),
    .out_c     (out_c)
  );

  // R3 reference
  function automatic int sine_ref(int unsigned ph);
    int i, x, m;
    i = int'((ph & 32'hFFFF) >> 6);
    x = i & 511;
    m = (x * (512 - x)) >> 9;
    if (m > 127) m = 127;
    return (i >= 512) ? -m : m;
  endfunction

  // R4 reference
  function automatic int duty_ref(int unsigned ph, int a);
    int s;
    s = sine_ref(ph);
    return 128 + ((s * a) >>> 8);
  endfunction

  task automatic check_bit(input string tag, input int k, input logic act, input logic exp_v);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s phase %0d actual %0b expected %0b", tag, k, act, exp_v);
    end
  endtask

  int          e_cnt = 0;
  int          comp_p = -1;
  int          set_p = -1;
  int          duty_act [3];
  int          staged [3];
  int unsigned acc = 0;
  bit          act_amp0 = 1'b0;
  bit          stg_amp0 = 1'b0;
  bit          held = 1'b0;

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired, actual running expected finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [2:0] outs;
    int cnt, per, nxt;
    string tag;
    void'($urandom(32'd4242));
    rst_n  = 1'b0;
    en     = 1'b0;
    freq_w = 16'd300;
    amp    = 8'd200;
    for (int k = 0; k < 3; k++) begin
      duty_act[k] = 0;
      staged[k]   = 0;
    end
    repeat (3) @(negedge clk);
    // R1: reset state
    check_bit("R1", 0, out_a, 1'b0);
    check_bit("R1", 1, out_b, 1'b0);
    check_bit("R1", 2, out_c, 1'b0);
    rst_n = 1'b1;

    for (int cyc = 0; cyc < 12000; cyc++) begin
      @(negedge clk);
      cnt = e_cnt % 256;
      per = e_cnt / 256;
      if (cnt == 0 && per != comp_p) begin
        // R5, R7: three samples from the current accumulator, then advance
        staged[0] = duty_ref(acc, int'(amp));
        staged[1] = duty_ref(acc + 21845, int'(amp));
        staged[2] = duty_ref(acc + 43690, int'(amp));
        stg_amp0  = (amp == 8'd0);
        acc       = (acc + freq_w) & 32'hFFFF;
        comp_p    = per;
      end
      outs = {out_c, out_b, out_a};
      for (int k = 0; k < 3; k++) begin
        if (per == 0)     tag = "R1";
        else if (held)    tag = "R8";
        else if (act_amp0) tag = "R9";
        else if (k > 0)   tag = "R5";
        else              tag = "R2 R3 R4 R6 R7";
        check_bit(tag, k, outs[k], (cnt < duty_act[k]) ? 1'b1 : 1'b0);
      end
      // new parameters mid-period, used at the next period start
      if (cnt == 128 && set_p != per) begin
        set_p = per;
        nxt = per + 1;
        case (nxt)
          2: begin amp = 8'd0;   freq_w = 16'd1000; end
          3: begin amp = 8'd255; freq_w = 16'd0;    end
          4: begin amp = 8'd255; freq_w = 16'hFFFF; end
          5: begin amp = 8'd128; freq_w = 16'h8000; end
          6: begin amp = 8'd255; freq_w = 16'h4000; end
          default: begin
            amp    = 8'($urandom_range(0, 255));
            freq_w = 16'($urandom_range(0, 65535));
          end
        endcase
      end
      // enable pattern: gaps in a band of periods, dense near the boundary
      if (per >= 7 && per <= 22) begin
        if (cnt >= 252 || cnt <= 5) en = ($urandom_range(0, 2) != 0);
        else                        en = ($urandom_range(0, 5) != 0);
      end else begin
        en = 1'b1;
      end
      if (en) begin
        if (cnt == 255) begin
          for (int k = 0; k < 3; k++) duty_act[k] = staged[k];
          act_amp0 = stg_amp0;
        end
        e_cnt++;
      end
      held = !en;
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule